// File: doc/BRIEF.md
# Video Test Pattern Generator

This block builds a 24-bit RGB test image, 8 bits per channel, one pixel per clock, from the active-video coordinates that a separate raster timing block supplies. A 4-bit pattern code picks the image: all black, saturated or 75%-amplitude colour bars, a vertical or horizontal comb of thin green lines, or a ramp on red, green, blue or all three channels. When the enable input is high the pattern drives the output and the valid flag is raised. When it is low the output is black with valid low, and the downstream mux keeps the live pixel path.

The coordinates are expected to scan in raster order: x counts up by one each clock from 0 along a line, and y counts lines from 0. The pattern code is taken only on the first pixel of a frame (x = 0, y = 0), so a frame never mixes two patterns. Every output is registered, and each pixel appears one clock after its coordinates.

Top module: `vtpg_top`

## Requirements
- R1: While reset (rst_n low) is held, and on the first clock after it, pix_r, pix_g and pix_b are 0 and pat_valid is 0.
- R2: When pat_en is 0 at a clock edge, the outputs after that edge are pat_valid = 0 and all three channels 0, whatever the pattern code.
- R3: When pat_en is 1, the outputs after the edge that samples coordinates (x, y) carry the pattern value for that pixel and pat_valid = 1. The latency is exactly one clock.
- R4: pat_sel is captured only on a clock whose coordinates are x = 0, y = 0, and that pixel already uses the new code. A change of pat_sel at any other pixel has no effect until the next frame start.
- R5: Code 0 (black) and the unused codes 9 to 15 give 0 on all channels.
- R6: Code 1 (full bars): the bar index is bits 8:6 of x, so eight 64-pixel bars repeat every 512 pixels. Blue is 255 when index bit 0 is set, red when bit 1 is set, green when bit 2 is set, and 0 otherwise. Left to right this gives black, blue, red, magenta, green, cyan, yellow, white.
- R7: Code 2 (75% bars) uses the same layout as R6, with 191 in place of 255.
- R8: Code 3 (vertical comb): green is 255 on pixels whose position counted from the line start is a multiple of 11 (x mod 11 = 0), and red and blue are 0. Every other pixel is black.
- R9: Code 4 (horizontal comb): every pixel of a line whose index in the frame is a multiple of 11 (y mod 11 = 0) is green 255. Every other line is black.
- R10: Codes 5, 6 and 7 ramp red, green and blue alone. Code 8 ramps all three channels equally. The ramp value is x/2 (integer division) for x < 512 and 255 from x = 512 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_en | input | 1 | Pattern enable from the control register |
| pat_sel | input | 4 | Pattern code, captured at frame start |
| x_pos | input | 12 | Active-video pixel column |
| y_pos | input | 11 | Active-video line index |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |
| pat_valid | output | 1 | Pattern is driving the output |

## Verification
Lines are a little wider than 512 pixels, and frames are 23 lines tall. This exercises bar wrap-around, the ramp clamp at 255 past x = 511, and comb rows 0, 11 and 22. A design with a bad clamp would restart its ramp at x = 512, and one with a bad wrap would show white instead of black there. Off-by-one comb counters would shift every green column or row by one. Throughout the run, pat_sel is changed at random pixels in mid-frame. A design that followed pat_sel at once would tear the image. In one frame pat_en toggles at random, which catches a valid flag or a blanking path that lags enable by a cycle.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;
   localparam int CH_W = 8;

   typedef enum logic [3:0] {
      PAT_BLACK    = 4'd0,
      PAT_BAR_FULL = 4'd1,
      PAT_BAR_PART = 4'd2,
      PAT_VCOMB    = 4'd3,
      PAT_HCOMB    = 4'd4,
      PAT_GRAD_R   = 4'd5,
      PAT_GRAD_G   = 4'd6,
      PAT_GRAD_B   = 4'd7,
      PAT_GRAD_W   = 4'd8
   } pat_e;

   typedef struct packed {
      logic [CH_W-1:0] r;
      logic [CH_W-1:0] g;
      logic [CH_W-1:0] b;
   } rgb_t;
endpackage

// File: rtl/vtpg_modcnt.sv
module vtpg_modcnt #(
   parameter int PERIOD = 11,
   localparam int CW = $clog2(PERIOD)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          adv,
   output logic [CW-1:0] cnt_now
);
   logic [CW-1:0] cnt_q;

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("vtpg_modcnt: PERIOD must be at least 2");
      end
   endgenerate

   always_comb begin
      if (clear)
         cnt_now = '0;
      else if (adv)
         cnt_now = (cnt_q == CW'(PERIOD - 1)) ? '0 : cnt_q + 1'b1;
      else
         cnt_now = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_now;
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(PERIOD)); // R8

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt_q == '0); // R9
endmodule

// File: rtl/vtpg_bars.sv
module vtpg_bars
   import vtpg_pkg::*;
#(
   parameter int BAR_W_LOG2 = 6,
   parameter int NBAR_LOG2  = 3,
   parameter int FULL_LVL   = 255,
   parameter int PART_LVL   = 191,
   localparam int IW = BAR_W_LOG2 + NBAR_LOG2
) (
   input  logic [IW-1:0] x_low,
   input  logic          partial,
   output rgb_t          bar_pix
);
   logic [NBAR_LOG2-1:0] idx;
   logic [CH_W-1:0]      lvl;

   generate
      if (NBAR_LOG2 != 3) begin : g_bad_bars
         $error("vtpg_bars: eight bars are needed for the colour order");
      end
      if (FULL_LVL > 255 || PART_LVL > FULL_LVL) begin : g_bad_lvl
         $error("vtpg_bars: bar levels out of range");
      end
   endgenerate

   assign idx = x_low[IW-1:BAR_W_LOG2];
   assign lvl = partial ? CH_W'(PART_LVL) : CH_W'(FULL_LVL);

   always_comb begin
      bar_pix.b = idx[0] ? lvl : '0;
      bar_pix.r = idx[1] ? lvl : '0;
      bar_pix.g = idx[2] ? lvl : '0;
   end
endmodule

// File: rtl/vtpg_ramp.sv
module vtpg_ramp
   import vtpg_pkg::*;
#(
   parameter int XW        = 12,
   parameter int STEP_LOG2 = 1
) (
   input  logic [XW-1:0]   x,
   output logic [CH_W-1:0] level
);
   localparam int MAXV = (1 << CH_W) - 1;

   logic [XW-1:0] steps;

   generate
      if (XW < CH_W + STEP_LOG2) begin : g_bad_xw
         $error("vtpg_ramp: x too narrow to span the ramp");
      end
      if (STEP_LOG2 == 0) begin : g_unit
         assign steps = x;
      end else begin : g_shift
         assign steps = x >> STEP_LOG2;
      end
   endgenerate

   assign level = (steps > XW'(MAXV)) ? CH_W'(MAXV) : steps[CH_W-1:0];
endmodule

// File: rtl/vtpg_top.sv
module vtpg_top
   import vtpg_pkg::*;
#(
   parameter int XW          = 12,
   parameter int YW          = 11,
   parameter int COMB_PERIOD = 11,
   parameter int FULL_LVL    = 255,
   parameter int PART_LVL    = 191,
   parameter int RAMP_STEP_LOG2 = 1,
   localparam int CW = $clog2(COMB_PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pat_en,
   input  logic [3:0]       pat_sel,
   input  logic [XW-1:0]    x_pos,
   input  logic [YW-1:0]    y_pos,
   output logic [CH_W-1:0]  pix_r,
   output logic [CH_W-1:0]  pix_g,
   output logic [CH_W-1:0]  pix_b,
   output logic             pat_valid
);
   localparam logic [CH_W-1:0] ON_LVL = CH_W'(FULL_LVL);

   logic            frame_start, line_start;
   logic [3:0]      held_sel_q, eff_sel;
   logic [CW-1:0]   col_cnt, row_cnt;
   rgb_t            bar_pix, next_pix, pix_q;
   logic [CH_W-1:0] ramp_lvl;
   logic            valid_q;

   generate
      if (XW < 10) begin : g_bad_x
         $error("vtpg_top: x must reach past 512");
      end
      if (YW < 4) begin : g_bad_y
         $error("vtpg_top: y too narrow");
      end
   endgenerate

   assign line_start  = (x_pos == '0);
   assign frame_start = line_start && (y_pos == '0);
   assign eff_sel     = frame_start ? pat_sel : held_sel_q;

   vtpg_modcnt #(.PERIOD(COMB_PERIOD)) u_col (
      .clk(clk), .rst_n(rst_n), .clear(line_start), .adv(1'b1),
      .cnt_now(col_cnt));

   vtpg_modcnt #(.PERIOD(COMB_PERIOD)) u_row (
      .clk(clk), .rst_n(rst_n), .clear(frame_start), .adv(line_start),
      .cnt_now(row_cnt));

   vtpg_bars #(.FULL_LVL(FULL_LVL), .PART_LVL(PART_LVL)) u_bars (
      .x_low(x_pos[8:0]), .partial(eff_sel == PAT_BAR_PART),
      .bar_pix(bar_pix));

   vtpg_ramp #(.XW(XW), .STEP_LOG2(RAMP_STEP_LOG2)) u_ramp (
      .x(x_pos), .level(ramp_lvl));

   always_comb begin
      next_pix = '0;
      case (eff_sel)
         PAT_BAR_FULL, PAT_BAR_PART: next_pix = bar_pix;
         PAT_VCOMB:  next_pix.g = (col_cnt == '0) ? ON_LVL : '0;
         PAT_HCOMB:  next_pix.g = (row_cnt == '0) ? ON_LVL : '0;
         PAT_GRAD_R: next_pix.r = ramp_lvl;
         PAT_GRAD_G: next_pix.g = ramp_lvl;
         PAT_GRAD_B: next_pix.b = ramp_lvl;
         PAT_GRAD_W: begin
            next_pix.r = ramp_lvl;
            next_pix.g = ramp_lvl;
            next_pix.b = ramp_lvl;
         end
         default: next_pix = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_sel_q <= 4'd0;
         pix_q      <= '0;
         valid_q    <= 1'b0;
      end else begin
         if (frame_start) held_sel_q <= pat_sel;
         pix_q   <= pat_en ? next_pix : '0;
         valid_q <= pat_en;
      end
   end

   assign pix_r     = pix_q.r;
   assign pix_g     = pix_q.g;
   assign pix_b     = pix_q.b;
   assign pat_valid = valid_q;

   AST_EN_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      pat_en |=> pat_valid); // R3

   AST_OFF_IS_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      !pat_en |=> (!pat_valid && pix_r == '0 && pix_g == '0 && pix_b == '0)); // R2

   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(held_sel_q)); // R4

   AST_PART_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_en && eff_sel == PAT_BAR_PART) |=>
         ((pix_r == '0 || pix_r == CH_W'(PART_LVL)) &&
          (pix_g == '0 || pix_g == CH_W'(PART_LVL)) &&
          (pix_b == '0 || pix_b == CH_W'(PART_LVL)))); // R7

   AST_COMB_GREEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_en && (eff_sel == PAT_VCOMB || eff_sel == PAT_HCOMB)) |=>
         (pix_r == '0 && pix_b == '0)); // R8
endmodule

// File: tb/sim_vtpg_top.sv
module sim_vtpg_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pat_en = 1'b0;
   logic [3:0]  pat_sel = 4'd0;
   logic [11:0] x_pos = '0;
   logic [10:0] y_pos = '0;
   logic [7:0]  pix_r, pix_g, pix_b;
   logic        pat_valid;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   logic [3:0]  model_sel = 4'd0;
   bit          pend = 1'b0;
   logic [24:0] pend_exp;
   string       pend_req;

   always #4 clk = ~clk;

   vtpg_top u0 (
      .clk(clk), .rst_n(rst_n), .pat_en(pat_en), .pat_sel(pat_sel),
      .x_pos(x_pos), .y_pos(y_pos), .pix_r(pix_r), .pix_g(pix_g),
      .pix_b(pix_b), .pat_valid(pat_valid));

   function automatic logic [7:0] ramp_of(int x);
      return (x >= 512) ? 8'd255 : 8'(x / 2);
   endfunction

   function automatic logic [23:0] pix_of(logic [3:0] sel, int x, int y);
      logic [2:0] idx;
      logic [7:0] lv, rv;
      idx = 3'((x % 512) / 64);
      rv  = ramp_of(x);
      case (sel)
         4'd1, 4'd2: begin
            lv = (sel == 4'd1) ? 8'd255 : 8'd191;
            return {idx[1] ? lv : 8'd0, idx[2] ? lv : 8'd0, idx[0] ? lv : 8'd0};
         end
         4'd3: return {8'd0, (x % 11 == 0) ? 8'd255 : 8'd0, 8'd0};
         4'd4: return {8'd0, (y % 11 == 0) ? 8'd255 : 8'd0, 8'd0};
         4'd5: return {rv, 8'd0, 8'd0};
         4'd6: return {8'd0, rv, 8'd0};
         4'd7: return {8'd0, 8'd0, rv};
         4'd8: return {rv, rv, rv};
         default: return 24'd0;
      endcase
   endfunction

   function automatic string req_of(logic [3:0] sel, logic en);
      if (!en) return "R2";
      case (sel)
         4'd1: return "R6 R3";
         4'd2: return "R7 R3";
         4'd3: return "R8 R3";
         4'd4: return "R9 R3";
         4'd5, 4'd6, 4'd7, 4'd8: return "R10 R3";
         default: return "R5 R3";
      endcase
   endfunction

   task automatic compare(logic [24:0] exp, string req);
      vectors++;
      if ({pat_valid, pix_r, pix_g, pix_b} !== exp) begin
         errors++;
         $display("FAIL %s: got valid=%0b rgb=%06h, expected valid=%0b rgb=%06h",
                  req, pat_valid, {pix_r, pix_g, pix_b}, exp[24], exp[23:0]);
      end
   endtask

   task automatic pixel(int x, int y, logic [3:0] sel, logic en);
      @(negedge clk);
      if (pend) compare(pend_exp, pend_req);
      x_pos   = 12'(x);
      y_pos   = 11'(y);
      pat_sel = sel;
      pat_en  = en;
      if (x == 0 && y == 0) model_sel = sel;
      pend     = 1'b1;
      pend_exp = {en, en ? pix_of(model_sel, x, y) : 24'd0};
      pend_req = req_of(model_sel, en);
      if (sel != model_sel) pend_req = {pend_req, " R4"};
   endtask

   initial begin
      logic [3:0] frame_pat [12] = '{4'd4, 4'd3, 4'd1, 4'd2, 4'd5, 4'd6,
                                     4'd7, 4'd8, 4'd0, 4'd12, 4'd1, 4'd3};
      logic [3:0] sel;
      logic       en;
      int         width;
      void'($urandom(32'd2025));
      repeat (3) @(negedge clk);
      compare(25'd0, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      compare(25'd0, "R1");
      @(posedge clk);
      @(negedge clk);
      compare(25'd0, "R1");
      for (int f = 0; f < 12; f++) begin
         width = 514 + int'($urandom % 16);
         for (int y = 0; y < 23; y++) begin
            for (int x = 0; x < width; x++) begin
               if (x == 0 && y == 0) sel = frame_pat[f];
               else if ($urandom % 97 == 0) sel = 4'($urandom % 16);
               en = (f == 10) ? ($urandom % 4 != 0) : 1'b1;
               pixel(x, y, sel, en);
            end
         end
      end
      @(negedge clk);
      if (pend) compare(pend_exp, pend_req);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got no finish, expected end of stimulus");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule